// File: doc/BRIEF.md
# Separable Switch Allocator with Output-VC Selection

This block decides, once per cycle, which buffered flits of a virtual-channel router may cross the crossbar. It allocates in two stages. In the first stage, every input port selects one of its ready VCs. In the second stage, every output port selects one of the inputs that asked for it. When the winner is a head flit, the block also reserves a free VC on that output port. When the winner is a body or tail flit, the block takes one credit from the VC its packet already holds.

Every input VC has a flat index `f = port*NVC + vc`. VC `v` belongs to virtual network `v / VPV`. Route and output-VC fields are packed per VC at `[f*PW +: PW]` and `[f*VW +: VW]`. The read, claim and consume strobes come out in the same cycle as the allocation, and the output-state tracker and the input buffers act on them. The crossbar select is registered, so the granted flit reaches the output link one cycle later. The parameter `ORDERED` changes both arbiter stages from round-robin to arrival order, which keeps point-to-point ordering.

Top module: `sa_separable_alloc`

## Requirements
- R1: Each input port offers at most one VC per cycle. In round-robin mode, the search starts at the VC after the last one that won a grant on that port (VC 0 after reset) and wraps around.
- R2: A VC holding a head flit (`in_head`=1) is eligible only if its routed output port has at least one `out_vc_free` bit set among the VCs of the head flit's virtual network.
- R3: A VC holding a body or tail flit (`in_head`=0) is eligible only if `out_vc_credit` is set for the output VC recorded in `in_outvc`. The free state has no effect on it.
- R4: Each output port grants at most one requesting input per cycle. In round-robin mode, the search starts at the input after the last input it granted (input 0 after reset).
- R5: An arbiter pointer moves only when a grant is actually issued. An input VC that wins the first stage but loses the second stage stays first in line on its port.
- R6: A winning head flit sets `vc_claim` at `port*NVC+vc`, where `vc` is the lowest-indexed free VC of its virtual network on its output port. The same `vc` index appears in `head_outvc` for the winning input.
- R7: A winning body or tail flit sets `vc_consume` at `port*NVC+in_outvc` and sets no claim. Each read matches exactly one claim or one consume.
- R8: `vc_read` has at most one bit set per input port. Each output port has at most one claim or consume bit set per cycle.
- R9: `xbar_valid[o]` and `xbar_sel[o*PW +: PW]` (the winning input's number) appear one cycle after the grant. The select is 0 when its output has no grant.
- R10: With `ORDERED`=1, both stages grant the oldest eligible requester. Age comes from `in_arrive` pulses (per VC) in stage one and from the rising edge of a request in stage two. When two requesters entered in the same cycle, or neither has any history, the lower index counts as older.
- R11: After reset, `xbar_valid` is 0, and every strobe is 0 while no VC is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT*NVC | Input VC holds a flit ready for allocation |
| in_head | input | NPORT*NVC | Front flit of the VC is a head (or single-flit) flit |
| in_arrive | input | NPORT*NVC | Pulse when a new packet enters the VC (arrival order) |
| in_outport | input | NPORT*NVC*PW | Routed output port of each input VC |
| in_outvc | input | NPORT*NVC*VW | Output VC already held by the VC's packet |
| out_vc_free | input | NPORT*NVC | Output VC is unassigned |
| out_vc_credit | input | NPORT*NVC | Output VC has at least one downstream buffer |
| vc_read | output | NPORT*NVC | Dequeue strobe for the granted input VC |
| vc_claim | output | NPORT*NVC | Output VC reserved by a winning head flit |
| vc_consume | output | NPORT*NVC | One credit taken from an output VC |
| head_outvc | output | NPORT*VW | Output VC given to a head flit, per input port |
| xbar_valid | output | NPORT | Registered: output port carries a flit this cycle |
| xbar_sel | output | NPORT*PW | Registered: input port steered to each output |

## Verification
The claim path for head flits and the consume path for body and tail flits can fire in the same cycle on two different output ports. A third VC whose body flit lacks a credit stays blocked during that same cycle. The bench sets up this mix and checks the exact claim, consume and read vectors together with both registered crossbar selects one cycle later. It also checks that the claimed VC is the lowest free one in the flit's virtual network when VC 0 of that network is busy. A second case has an input port win the first stage and then lose the output: the bench confirms that the next cycle picks the same VC again and does not pick a different one.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {
    ARB_ROUND_ROBIN = 1'b0,
    ARB_ARRIVAL     = 1'b1
  } arb_kind_e;
endpackage

// File: rtl/sa_arbiter.sv
module sa_arbiter
  import sa_pkg::*;
#(
  parameter int        N    = 4,
  parameter arb_kind_e KIND = ARB_ROUND_ROBIN,
  localparam int       IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  enter,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);

  if (KIND == ARB_ROUND_ROBIN) begin : g_rr
    logic [IW-1:0] ptr_q, ptr_d;
    logic          unused_enter;
    assign unused_enter = ^enter;

    always_comb begin
      int c;
      logic hit;
      gnt = '0;
      gnt_idx = '0;
      hit = 1'b0;
      for (int k = 0; k < N; k++) begin
        c = (int'(ptr_q) + k) % N;
        if (!hit && req[c]) begin
          hit = 1'b1;
          gnt[c] = 1'b1;
          gnt_idx = IW'(c);
        end
      end
    end

    always_comb begin
      ptr_d = ptr_q;
      if (take && |gnt)
        ptr_d = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (take) ptr_q <= ptr_d;
    end
  end else begin : g_age
    // older_q[i][j] set: requester i entered before requester j
    logic [N-1:0][N-1:0] older_q, older_d;
    logic                unused_take;
    assign unused_take = take;

    always_comb begin
      logic blocked, hit;
      gnt = '0;
      gnt_idx = '0;
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
        blocked = 1'b0;
        for (int j = 0; j < N; j++)
          if (j != i && req[j] && older_q[j][i]) blocked = 1'b1;
        if (!hit && req[i] && !blocked) begin
          hit = 1'b1;
          gnt[i] = 1'b1;
          gnt_idx = IW'(i);
        end
      end
    end

    always_comb begin
      older_d = older_q;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j) begin
            if (enter[i] && enter[j]) older_d[i][j] = (i < j);
            else if (enter[i])        older_d[i][j] = 1'b0;
            else if (enter[j])        older_d[i][j] = 1'b1;
          end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            older_q[i][j] <= (i < j);
      end else if (|enter) begin
        older_q <= older_d;
      end
    end
  end

endmodule

// File: rtl/sa_vc_select.sv
module sa_vc_select #(
  parameter int  NVNET = 2,
  parameter int  VPV   = 2,
  localparam int NVC   = NVNET * VPV,
  localparam int VW    = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int VNW   = (NVNET > 1) ? $clog2(NVNET) : 1
) (
  input  logic [NVC-1:0] free_vc,
  input  logic [VNW-1:0] vnet,
  output logic [NVC-1:0] pick_oh,
  output logic [VW-1:0]  pick_idx
);

  always_comb begin
    int c;
    logic hit;
    pick_oh = '0;
    pick_idx = '0;
    hit = 1'b0;
    for (int k = 0; k < VPV; k++) begin
      c = int'(vnet) * VPV + k;
      if (!hit && c < NVC && free_vc[c]) begin
        hit = 1'b1;
        pick_oh[c] = 1'b1;
        pick_idx = VW'(c);
      end
    end
  end

endmodule

// File: rtl/sa_separable_alloc.sv
module sa_separable_alloc
  import sa_pkg::*;
#(
  parameter int  NPORT   = 3,
  parameter int  NVNET   = 2,
  parameter int  VPV     = 2,
  parameter bit  ORDERED = 1'b0,
  localparam int NVC     = NVNET * VPV,
  localparam int NF      = NPORT * NVC,
  localparam int PW      = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VW      = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int VNW     = (NVNET > 1) ? $clog2(NVNET) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NF-1:0]      in_valid,
  input  logic [NF-1:0]      in_head,
  input  logic [NF-1:0]      in_arrive,
  input  logic [NF*PW-1:0]   in_outport,
  input  logic [NF*VW-1:0]   in_outvc,
  input  logic [NF-1:0]      out_vc_free,
  input  logic [NF-1:0]      out_vc_credit,
  output logic [NF-1:0]      vc_read,
  output logic [NF-1:0]      vc_claim,
  output logic [NF-1:0]      vc_consume,
  output logic [NPORT*VW-1:0] head_outvc,
  output logic [NPORT-1:0]   xbar_valid,
  output logic [NPORT*PW-1:0] xbar_sel
);

  localparam arb_kind_e KIND = ORDERED ? ARB_ARRIVAL : ARB_ROUND_ROBIN;

  logic [NF-1:0]                 elig;
  logic [NPORT-1:0][NVC-1:0]     pick_oh;
  logic [NPORT-1:0][VW-1:0]      pick_idx;
  logic [NPORT-1:0][PW-1:0]      pick_port;
  logic [NPORT-1:0]              in_win;
  logic [NPORT-1:0][NPORT-1:0]   out_req, out_req_q, out_gnt;
  logic [NPORT-1:0][PW-1:0]      out_idx;
  logic [NPORT-1:0]              out_any;
  logic [NPORT-1:0]              win_head;
  logic [NPORT-1:0][VNW-1:0]     win_vn;
  logic [NPORT-1:0][VW-1:0]      win_ov;
  logic [NPORT-1:0][NVC-1:0]     sel_oh;
  logic [NPORT-1:0][VW-1:0]      sel_idx;
  logic [NPORT-1:0]              xv_d, xv_q;
  logic [NPORT*PW-1:0]           xs_d, xs_q;

  // eligibility by flit kind
  always_comb begin
    int op, vn;
    logic any_free;
    elig = '0;
    for (int f = 0; f < NF; f++) begin
      op = int'(in_outport[f*PW +: PW]);
      vn = (f % NVC) / VPV;
      any_free = 1'b0;
      if (op < NPORT) begin
        for (int k = 0; k < VPV; k++)
          any_free = any_free | out_vc_free[op*NVC + vn*VPV + k];
        elig[f] = in_valid[f] &&
                  (in_head[f] ? any_free
                              : out_vc_credit[op*NVC + int'(in_outvc[f*VW +: VW])]);
      end
    end
  end

  // stage one: one VC per input port
  for (genvar p = 0; p < NPORT; p++) begin : g_in
    sa_arbiter #(.N(NVC), .KIND(KIND)) u_in_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (elig[p*NVC +: NVC]),
      .enter   (in_arrive[p*NVC +: NVC]),
      .take    (in_win[p]),
      .gnt     (pick_oh[p]),
      .gnt_idx (pick_idx[p])
    );
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      pick_port[p] = in_outport[(p*NVC + int'(pick_idx[p]))*PW +: PW];
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int p = 0; p < NPORT; p++)
        out_req[o][p] = (|pick_oh[p]) && (int'(pick_port[p]) == o);
  end

  // stage two: one input per output port, plus output-VC choice
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    sa_arbiter #(.N(NPORT), .KIND(KIND)) u_out_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (out_req[o]),
      .enter   (out_req[o] & ~out_req_q[o]),
      .take    (out_any[o]),
      .gnt     (out_gnt[o]),
      .gnt_idx (out_idx[o])
    );
    sa_vc_select #(.NVNET(NVNET), .VPV(VPV)) u_vc_sel (
      .free_vc  (out_vc_free[o*NVC +: NVC]),
      .vnet     (win_vn[o]),
      .pick_oh  (sel_oh[o]),
      .pick_idx (sel_idx[o])
    );
    assign out_any[o] = |out_req[o];
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      in_win[p] = 1'b0;
      for (int o = 0; o < NPORT; o++)
        in_win[p] = in_win[p] | out_gnt[o][p];
    end
  end

  always_comb begin
    int p, wf;
    for (int o = 0; o < NPORT; o++) begin
      p = int'(out_idx[o]);
      wf = p*NVC + int'(pick_idx[p]);
      win_head[o] = in_head[wf];
      win_vn[o] = VNW'(int'(pick_idx[p]) / VPV);
      win_ov[o] = in_outvc[wf*VW +: VW];
    end
  end

  // strobes toward input buffers and output-VC tracker
  always_comb begin
    int p;
    vc_claim = '0;
    vc_consume = '0;
    head_outvc = '0;
    for (int o = 0; o < NPORT; o++) begin
      p = int'(out_idx[o]);
      if (out_any[o]) begin
        if (win_head[o]) begin
          vc_claim[o*NVC +: NVC] = sel_oh[o];
          head_outvc[p*VW +: VW] = sel_idx[o];
        end else begin
          vc_consume[o*NVC + int'(win_ov[o])] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      vc_read[p*NVC +: NVC] = in_win[p] ? pick_oh[p] : '0;
  end

  // crossbar control for the link cycle
  always_comb begin
    xv_d = out_any;
    xs_d = '0;
    for (int o = 0; o < NPORT; o++)
      if (out_any[o]) xs_d[o*PW +: PW] = out_idx[o];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xv_q      <= '0;
      xs_q      <= '0;
      out_req_q <= '0;
    end else begin
      xv_q      <= xv_d;
      xs_q      <= xs_d;
      out_req_q <= out_req;
    end
  end

  assign xbar_valid = xv_q;
  assign xbar_sel   = xs_q;

endmodule

// File: rtl/sa_alloc_chk.sv
module sa_alloc_chk #(
  parameter int  NPORT = 3,
  parameter int  NVC   = 4,
  localparam int NF    = NPORT * NVC
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NF-1:0]    vc_read,
  input logic [NF-1:0]    vc_claim,
  input logic [NF-1:0]    vc_consume,
  input logic [NF-1:0]    out_vc_free,
  input logic [NF-1:0]    out_vc_credit,
  input logic [NPORT-1:0] xbar_valid
);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assert_one_read_per_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vc_read[p*NVC +: NVC]));
    assert_one_strobe_per_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({vc_claim[p*NVC +: NVC], vc_consume[p*NVC +: NVC]}) <= 1);
  end

  assert_claim_only_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_claim & ~out_vc_free) == '0);

  assert_consume_needs_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_consume & ~out_vc_credit) == '0);

  assert_strobe_per_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_claim) + $countones(vc_consume) == $countones(vc_read));

  assert_link_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ($countones(xbar_valid) == $past($countones(vc_read))));

endmodule

bind sa_separable_alloc sa_alloc_chk #(.NPORT(NPORT), .NVC(NVNET*VPV)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vc_read       (vc_read),
  .vc_claim      (vc_claim),
  .vc_consume    (vc_consume),
  .out_vc_free   (out_vc_free),
  .out_vc_credit (out_vc_credit),
  .xbar_valid    (xbar_valid)
);

// File: tb/sim_sa_separable_alloc.sv
module sim_sa_separable_alloc;
  localparam int NPORT = 3;
  localparam int NVNET = 2;
  localparam int VPV   = 2;
  localparam int NVC   = NVNET * VPV;
  localparam int NF    = NPORT * NVC;
  localparam int PW    = 2;
  localparam int VW    = 2;

  logic clk, rst_n;
  logic [NF-1:0]       in_valid, in_head, in_arrive, out_vc_free, out_vc_credit;
  logic [NF*PW-1:0]    in_outport;
  logic [NF*VW-1:0]    in_outvc;
  logic [NF-1:0]       vc_read, vc_claim, vc_consume;
  logic [NPORT*VW-1:0] head_outvc;
  logic [NPORT-1:0]    xbar_valid;
  logic [NPORT*PW-1:0] xbar_sel;
  logic [NF-1:0]       o_read, o_claim, o_consume;
  logic [NPORT*VW-1:0] o_hvc;
  logic [NPORT-1:0]    o_xv;
  logic [NPORT*PW-1:0] o_xs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit                  q_chk[$];
  logic [NPORT-1:0]    q_xv[$];
  logic [NPORT*PW-1:0] q_xs[$];
  string               q_tag[$];

  sa_separable_alloc #(.NPORT(NPORT), .NVNET(NVNET), .VPV(VPV), .ORDERED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
    .in_arrive(in_arrive), .in_outport(in_outport), .in_outvc(in_outvc),
    .out_vc_free(out_vc_free), .out_vc_credit(out_vc_credit),
    .vc_read(vc_read), .vc_claim(vc_claim), .vc_consume(vc_consume),
    .head_outvc(head_outvc), .xbar_valid(xbar_valid), .xbar_sel(xbar_sel));

  sa_separable_alloc #(.NPORT(NPORT), .NVNET(NVNET), .VPV(VPV), .ORDERED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
    .in_arrive(in_arrive), .in_outport(in_outport), .in_outvc(in_outvc),
    .out_vc_free(out_vc_free), .out_vc_credit(out_vc_credit),
    .vc_read(o_read), .vc_claim(o_claim), .vc_consume(o_consume),
    .head_outvc(o_hvc), .xbar_valid(o_xv), .xbar_sel(o_xs));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [NF-1:0] b(int i);
    return NF'(1) << i;
  endfunction

  function automatic logic [NPORT*PW-1:0] xs(int o, int p);
    return (NPORT*PW)'(p) << (o*PW);
  endfunction

  task automatic clr();
    in_valid = '0; in_head = '0; in_arrive = '0;
    in_outport = '0; in_outvc = '0; out_vc_free = '0; out_vc_credit = '0;
  endtask

  task automatic put_vc(int p, int v, bit head, int op, int ov);
    int f;
    f = p*NVC + v;
    in_valid[f] = 1'b1;
    in_head[f] = head;
    in_outport[f*PW +: PW] = PW'(op);
    in_outvc[f*VW +: VW] = VW'(ov);
  endtask

  task automatic chk_vec(string tag, string what, logic [NF-1:0] act, logic [NF-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_hvc(string tag, int p, int exp);
    checks++;
    if (head_outvc[p*VW +: VW] !== VW'(exp)) begin
      fails++;
      $display("FAIL %s head_outvc[%0d]: actual %0d expected %0d", tag, p,
               head_outvc[p*VW +: VW], exp);
    end
  endtask

  // driver: check same-cycle strobes, queue the expected link-cycle crossbar state
  task automatic step(string tag, logic [NF-1:0] e_rd, logic [NF-1:0] e_cl,
                      logic [NF-1:0] e_cs, logic [NPORT-1:0] e_xv,
                      logic [NPORT*PW-1:0] e_xs);
    #1;
    chk_vec(tag, "vc_read", vc_read, e_rd);
    chk_vec(tag, "vc_claim", vc_claim, e_cl);
    chk_vec(tag, "vc_consume", vc_consume, e_cs);
    q_chk.push_back(1'b1); q_xv.push_back(e_xv); q_xs.push_back(e_xs); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic ostep(string tag, logic [NF-1:0] e_rd);
    #1;
    chk_vec(tag, "ordered vc_read", o_read, e_rd);
    q_chk.push_back(1'b0); q_xv.push_back('0); q_xs.push_back('0); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares the registered crossbar state after each edge
  always @(posedge clk) begin
    #1;
    if (q_chk.size() > 0) begin
      bit c;
      logic [NPORT-1:0] ev;
      logic [NPORT*PW-1:0] es;
      string t;
      c = q_chk.pop_front(); ev = q_xv.pop_front(); es = q_xs.pop_front(); t = q_tag.pop_front();
      if (c) begin
        checks++;
        if (xbar_valid !== ev || xbar_sel !== es) begin
          fails++;
          $display("FAIL %s R9 xbar: actual valid %b sel %b expected valid %b sel %b",
                   t, xbar_valid, xbar_sel, ev, es);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: idle after reset
    step("R11 idle", '0, '0, '0, '0, '0);

    // R2/R6: head in vnet1 claims lowest free VC of port 1
    clr(); put_vc(0, 2, 1, 1, 0); out_vc_free = b(6) | b(7);
    #1; chk_hvc("R6 head vc", 0, 2); #0;
    step("R2 head grant", b(2), b(6), '0, 3'b010, xs(1, 0));

    // R2: only other-vnet VC free -> blocked; then VC3 free -> claimed
    clr(); put_vc(0, 2, 1, 1, 0); out_vc_free = b(5);
    step("R2 wrong vnet blocked", '0, '0, '0, '0, '0);
    out_vc_free = b(5) | b(7);
    #1; chk_hvc("R6 head vc3", 0, 3); #0;
    step("R6 claim vc3", b(2), b(7), '0, 3'b010, xs(1, 0));

    // R3: body waits for credit, free state irrelevant
    clr(); put_vc(1, 0, 0, 2, 1); out_vc_free = '1;
    step("R3 no credit", '0, '0, '0, '0, '0);
    out_vc_credit = b(9);
    step("R7 body consume", b(4), '0, b(9), 3'b100, xs(2, 1));

    // R4: two inputs on output 0 alternate
    clr(); put_vc(0, 0, 1, 0, 0); put_vc(2, 0, 1, 0, 0); out_vc_free = '1;
    step("R4 out rr first", b(0), b(0), '0, 3'b001, xs(0, 0));
    step("R4 out rr second", b(8), b(0), '0, 3'b001, xs(0, 2));

    // R1: input 1 rotates between VC2 and VC0
    clr(); put_vc(1, 0, 1, 2, 0); put_vc(1, 2, 1, 1, 0); out_vc_free = '1;
    step("R1 in rr a", b(6), b(6), '0, 3'b010, xs(1, 1));
    step("R1 in rr b", b(4), b(8), '0, 3'b100, xs(2, 1));
    step("R1 in rr c", b(6), b(6), '0, 3'b010, xs(1, 1));

    // R5: input 1 loses output 0, then picks the same VC again
    clr(); put_vc(0, 0, 1, 0, 0); put_vc(1, 0, 1, 0, 0); put_vc(1, 2, 1, 1, 0);
    out_vc_free = '1;
    step("R5 lose output", b(0), b(0), '0, 3'b001, xs(0, 0));
    in_valid[0] = 1'b0;
    step("R5 same vc retried", b(4), b(0), '0, 3'b001, xs(0, 1));

    // R6/R7/R8: claim and consume on different ports in one cycle, one blocked body
    clr(); put_vc(0, 1, 1, 2, 0); put_vc(1, 3, 0, 1, 3); put_vc(2, 1, 0, 0, 1);
    out_vc_free = b(9); out_vc_credit = b(7);
    #1; chk_hvc("R6 lowest free skips busy", 0, 1); #0;
    step("R8 claim+consume", b(1) | b(7), b(9), b(7), 3'b110, xs(2, 0) | xs(1, 1));

    // R10: arrival order on the ordered instance
    clr(); put_vc(0, 1, 1, 1, 0); in_arrive = b(1);
    ostep("R10 arrive vc1", '0);
    in_arrive = b(0); put_vc(0, 0, 1, 2, 0);
    ostep("R10 arrive vc0", '0);
    in_arrive = '0; out_vc_free = '1;
    ostep("R10 oldest first", b(1));
    in_valid[1] = 1'b0;
    ostep("R10 next in queue", b(0));

    clr();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule